// File: doc/BRIEF.md
# Serial Memory Status Register and Write Guard

This block sits beside the command engine of a serial memory device. It keeps the status byte: a volatile write-enable latch, a busy flag for the internal program cycle, two block-protect bits that pick a protected region at the top of the array, and, in the large-memory variant, a bit that arms the write-protect pin. The engine asks it whether an array write or a status write may commit, asks whether each target byte lies in the protected region, and reads the status byte from it when the host polls the status.

An accepted commit clears the write-enable latch and starts a busy window of a fixed number of clocks. During that window no command changes the state, and the protect pin cannot shorten the window. A parameter picks the large variant, where the pin blocks only status writes and only when armed, or the small variant, where the pin blocks both kinds of write. The stored protect bits take their reset values from parameters, which stand in for their nonvolatile storage.

Top module: `sr_guard`

## Requirements
- R1: While reset is asserted and after its release, the write-enable latch and busy flag are 0 and the protect bits and pin-arm bit hold their parameter values (default 0).
- R2: The status byte is {arm, 0, 0, 0, bp[1], bp[0], wen, busy} in the large variant and {1, 1, 1, 1, bp[1], bp[0], wen, busy} in the small variant, with busy in bit 0 and 1 meaning busy.
- R3: `byte_ok` is 0 exactly when `chk_addr` lies in the protected region: bp=00 none, bp=01 the two top address bits both 1, bp=10 the top address bit 1, bp=11 every address.
- R4: When idle, a pulse on `wren_cmd` sets the write-enable latch one cycle later and a pulse on `wrdi_cmd` clears it (clear wins if both).
- R5: Neither grant is given while the write-enable latch is 0; a request made then changes no state.
- R6: A granted array write or status write clears the write-enable latch and holds busy at 1 for exactly WCYC cycles, starting the cycle after the request.
- R7: Large variant: `wr_protect_n` low denies a status write only when the arm bit is 1 and never denies an array write. Small variant: `wr_protect_n` low denies both.
- R8: A granted status write loads bp from `wrsr_data[3:2]` and (large variant only) the arm bit from `wrsr_data[7]`; all other data bits are ignored.
- R9: Busy rises only after a granted request, and the protect pin going low during the busy window does not shorten it.
- R10: While busy, both grants are 0 and `wren_cmd`, `wrdi_cmd`, `wr_start` and `wrsr_req` change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| wren_cmd | input | 1 | One-cycle pulse: set write-enable latch |
| wrdi_cmd | input | 1 | One-cycle pulse: clear write-enable latch |
| wr_start | input | 1 | One-cycle pulse: array write wishes to commit |
| wrsr_req | input | 1 | One-cycle pulse: status write wishes to commit |
| wrsr_data | input | 8 | Byte carried by the status write |
| wr_protect_n | input | 1 | Write-protect pin, active low |
| chk_addr | input | ADDR_W | Byte address queried for protection |
| write_grant | output | 1 | An array write may commit this cycle |
| wrsr_grant | output | 1 | A status write may commit this cycle |
| byte_ok | output | 1 | `chk_addr` lies outside the protected region |
| status_byte | output | 8 | Status byte for the status read |

## Verification
The assertions watch, on every cycle, that a granted array write clears the latch and raises busy, that a denied status write (latch clear, or armed pin low) leaves the upper status bits untouched, that busy never rises without a granted request and always lasts exactly WCYC cycles, that no grant is given while busy, and that full protection denies every address. The exact region boundaries for each bp value, the bit layout of both variants, which data bits a status write keeps, and the latch set and clear sequences are shown only by the bench, which runs both variants side by side against a reference model under directed boundary cases and random command mixes with the pin toggling.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;

    typedef struct packed {
        logic       wen;
        logic [1:0] bp;
        logic       arm;
    } sr_state_t;

    typedef struct packed {
        logic [31:0] cnt;
        logic        busy;
    } tmr_state_t;

endpackage

// File: rtl/sr_range_decode.sv
module sr_range_decode #(
    parameter int ADDR_W = 13
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int TOP = ADDR_W - 1;
    localparam int NXT = ADDR_W - 2;

    logic upper_half;
    logic upper_quarter;

    assign upper_half    = addr[TOP];
    assign upper_quarter = addr[TOP] & addr[NXT];

    always_comb begin
        unique case (bp)
            2'b00:   hit = 1'b0;
            2'b01:   hit = upper_quarter;
            2'b10:   hit = upper_half;
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/sr_busy_timer.sv
module sr_busy_timer #(
    parameter int WCYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    import sr_guard_pkg::*;

    localparam logic [31:0] LAST = 32'(WCYC - 1);

    tmr_state_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.busy = 1'b1;
            t_d.cnt  = LAST;
        end else if (t_q.busy) begin
            if (t_q.cnt == 32'd0) t_d.busy = 1'b0;
            else                  t_d.cnt  = t_q.cnt - 32'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy = t_q.busy;
endmodule

// File: rtl/sr_guard.sv
module sr_guard #(
    parameter int         ADDR_W    = 13,
    parameter bit         LARGE     = 1'b1,
    parameter logic [1:0] BP_INIT   = 2'b00,
    parameter bit         ARM_INIT  = 1'b0,
    parameter int         WCYC      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wren_cmd,
    input  logic              wrdi_cmd,
    input  logic              wr_start,
    input  logic              wrsr_req,
    input  logic [7:0]        wrsr_data,
    input  logic              wr_protect_n,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              write_grant,
    output logic              wrsr_grant,
    output logic              byte_ok,
    output logic [7:0]        status_byte
);
    import sr_guard_pkg::*;

    localparam sr_state_t RST_VAL = '{wen: 1'b0, bp: BP_INIT, arm: ARM_INIT};

    sr_state_t st_d, st_q;
    logic      busy;
    logic      prot_hit;
    logic      pin_ok_wr;
    logic      pin_ok_sr;
    logic      wr_go;
    logic      sr_go;
    logic      unused_bits;

    assign unused_bits = ^{wrsr_data[6:4], wrsr_data[1:0]};

    sr_range_decode #(.ADDR_W(ADDR_W)) u_rng (
        .bp   (st_q.bp),
        .addr (chk_addr),
        .hit  (prot_hit)
    );

    generate
        if (LARGE) begin : g_large
            assign pin_ok_wr   = 1'b1;
            assign pin_ok_sr   = wr_protect_n | ~st_q.arm;
            assign status_byte = {st_q.arm, 3'b000, st_q.bp, st_q.wen, busy};
        end else begin : g_small
            assign pin_ok_wr   = wr_protect_n;
            assign pin_ok_sr   = wr_protect_n;
            assign status_byte = {4'hF, st_q.bp, st_q.wen, busy};
        end
    endgenerate

    assign write_grant = st_q.wen & ~busy & pin_ok_wr;
    assign wrsr_grant  = st_q.wen & ~busy & pin_ok_sr;
    assign byte_ok     = ~prot_hit;
    assign wr_go       = wr_start & write_grant;
    assign sr_go       = wrsr_req & wrsr_grant;

    sr_busy_timer #(.WCYC(WCYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_go | sr_go),
        .busy  (busy)
    );

    always_comb begin
        st_d = st_q;
        if (sr_go) begin
            st_d.bp  = wrsr_data[3:2];
            st_d.arm = LARGE ? wrsr_data[7] : 1'b0;
        end
        if (wr_go | sr_go) begin
            st_d.wen = 1'b0;
        end else if (!busy) begin
            if (wrdi_cmd)      st_d.wen = 1'b0;
            else if (wren_cmd) st_d.wen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= st_d;
    end
endmodule

module sr_guard_chk #(
    parameter int WCYC = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_start,
    input logic       wrsr_req,
    input logic       wr_protect_n,
    input logic       write_grant,
    input logic       wrsr_grant,
    input logic       byte_ok,
    input logic [7:0] status_byte
);
    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              run_q <= '0;
        else if (!status_byte[0]) run_q <= '0;
        else                     run_q <= run_q + 32'd1;
    end

    AST_FULL_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[3:2] == 2'b11) |-> !byte_ok); // R3

    AST_DENY_NO_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wrsr_req && !status_byte[1]) |=> $stable(status_byte[7:2])); // R5

    AST_COMMIT_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start && write_grant) |=> (!status_byte[1] && status_byte[0])); // R6

    AST_PIN_BLOCKS_WRSR: assert property (@(posedge clk) disable iff (!rst_n)
        (wrsr_req && !wr_protect_n && status_byte[7]) |=> $stable(status_byte[7:2])); // R7

    AST_BUSY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_byte[0]) |-> $past((wr_start && write_grant) || (wrsr_req && wrsr_grant))); // R9

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_byte[0]) |-> (run_q == 32'(WCYC))); // R9

    AST_NO_GRANT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[0] |-> (!write_grant && !wrsr_grant)); // R10
endmodule

bind sr_guard sr_guard_chk #(.WCYC(WCYC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_start     (wr_start),
    .wrsr_req     (wrsr_req),
    .wr_protect_n (wr_protect_n),
    .write_grant  (write_grant),
    .wrsr_grant   (wrsr_grant),
    .byte_ok      (byte_ok),
    .status_byte  (status_byte)
);

// File: tb/sr_guard_test.sv
module sr_guard_test;
    localparam int PERIOD = 10;
    localparam int AW     = 13;
    localparam int WC     = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wren_cmd = 1'b0, wrdi_cmd = 1'b0, wr_start = 1'b0, wrsr_req = 1'b0;
    logic [7:0]    wrsr_data = 8'h00;
    logic          wr_protect_n = 1'b1;
    logic [AW-1:0] chk_addr = '0;

    logic [7:0] st_o [2];
    logic       wg_o [2];
    logic       sg_o [2];
    logic       bo_o [2];

    int nchk = 0;
    int nerr = 0;

    bit       m_wen  [2];
    bit [1:0] m_bp   [2];
    bit       m_arm  [2];
    int       m_cnt  [2];

    always #(PERIOD/2) clk = ~clk;

    sr_guard #(.ADDR_W(AW), .LARGE(1'b1), .WCYC(WC)) uut (
        .clk(clk), .rst_n(rst_n), .wren_cmd(wren_cmd), .wrdi_cmd(wrdi_cmd),
        .wr_start(wr_start), .wrsr_req(wrsr_req), .wrsr_data(wrsr_data),
        .wr_protect_n(wr_protect_n), .chk_addr(chk_addr),
        .write_grant(wg_o[0]), .wrsr_grant(sg_o[0]), .byte_ok(bo_o[0]),
        .status_byte(st_o[0]));

    sr_guard #(.ADDR_W(AW), .LARGE(1'b0), .WCYC(WC)) uut_s (
        .clk(clk), .rst_n(rst_n), .wren_cmd(wren_cmd), .wrdi_cmd(wrdi_cmd),
        .wr_start(wr_start), .wrsr_req(wrsr_req), .wrsr_data(wrsr_data),
        .wr_protect_n(wr_protect_n), .chk_addr(chk_addr),
        .write_grant(wg_o[1]), .wrsr_grant(sg_o[1]), .byte_ok(bo_o[1]),
        .status_byte(st_o[1]));

    function automatic bit prot(input bit [1:0] bp, input logic [AW-1:0] a);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return a[AW-1] & a[AW-2];
            2'b10:   return a[AW-1];
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] exp_status(input int v);
        logic [7:0] s;
        if (v == 0) s = {m_arm[0], 3'b000, m_bp[0], m_wen[0], 1'b0};
        else        s = {4'hF, m_bp[1], m_wen[1], 1'b0};
        s[0] = (m_cnt[v] > 0);
        return s;
    endfunction

    function automatic bit exp_wg(input int v, input bit pin);
        return m_wen[v] && (m_cnt[v] == 0) && (v == 0 || pin);
    endfunction

    function automatic bit exp_sg(input int v, input bit pin);
        return m_wen[v] && (m_cnt[v] == 0) && !(!pin && (v == 0 ? m_arm[v] : 1'b1));
    endfunction

    task automatic check(input string req, input int v, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s variant=%0d actual=%h expected=%h at %0t", req, v, act, exp, $time);
        end
    endtask

    // op: 0 idle, 1 wren, 2 wrdi, 3 array write, 4 status write
    task automatic step(input int op, input bit pin, input logic [7:0] data, input logic [AW-1:0] addr);
        bit go [2];
        wren_cmd     = (op == 1);
        wrdi_cmd     = (op == 2);
        wr_start     = (op == 3);
        wrsr_req     = (op == 4);
        wrsr_data    = data;
        wr_protect_n = pin;
        chk_addr     = addr;
        #1;
        for (int v = 0; v < 2; v++) begin
            check("R5 R7 write_grant", v, 8'(wg_o[v]), 8'(exp_wg(v, pin)));
            check("R5 R7 wrsr_grant", v, 8'(sg_o[v]), 8'(exp_sg(v, pin)));
            check("R3 byte_ok", v, 8'(bo_o[v]), 8'(!prot(m_bp[v], addr)));
            go[v] = (op == 3 && exp_wg(v, pin)) || (op == 4 && exp_sg(v, pin));
        end
        for (int v = 0; v < 2; v++) begin
            if (go[v]) begin
                m_wen[v] = 1'b0;
                m_cnt[v] = WC;
                if (op == 4) begin
                    m_bp[v]  = data[3:2];
                    m_arm[v] = (v == 0) ? data[7] : 1'b0;
                end
            end else if (m_cnt[v] > 0) begin
                m_cnt[v]--;
            end else begin
                if (op == 1) m_wen[v] = 1'b1;
                if (op == 2) m_wen[v] = 1'b0;
            end
        end
        @(negedge clk);
        for (int v = 0; v < 2; v++) check("R2 R6 status_byte", v, st_o[v], exp_status(v));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 1'b1, 8'h00, '0);
    endtask

    initial begin
        #(PERIOD * 200000);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        void'($urandom(32'h1A2B3C));
        for (int v = 0; v < 2; v++) begin
            m_wen[v] = 0; m_bp[v] = 0; m_arm[v] = 0; m_cnt[v] = 0;
        end
        repeat (2) @(negedge clk);
        check("R1 reset status", 0, st_o[0], 8'h00);
        check("R1 reset status", 1, st_o[1], 8'hF0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 status after release", 0, st_o[0], 8'h00);
        check("R1 status after release", 1, st_o[1], 8'hF0);

        // R5: writes without the latch are refused
        step(3, 1'b1, 8'h00, '0);
        step(4, 1'b1, 8'hFF, '0);
        // R4: set then clear the latch
        step(1, 1'b1, 8'h00, '0);
        step(2, 1'b1, 8'h00, '0);
        // R7: array write with pin low, large granted, small refused
        step(1, 1'b1, 8'h00, '0);
        step(3, 1'b0, 8'h00, '0);
        // R6 R9 R10: pin low and commands during the busy window
        step(1, 1'b0, 8'h00, '0);
        step(4, 1'b0, 8'h0C, '0);
        step(2, 1'b0, 8'h00, '0);
        idle(WC);
        // R8: status write keeps only protect and arm bits
        step(1, 1'b1, 8'h00, '0);
        step(4, 1'b1, 8'h77, '0);
        idle(WC);
        // R3: region boundaries for bp=01 (data 0x04 keeps bp=01)
        step(1, 1'b1, 8'h00, '0);
        step(4, 1'b1, 8'h04, '0);
        idle(WC);
        step(0, 1'b1, 8'h00, 13'h17FF);
        step(0, 1'b1, 8'h00, 13'h1800);
        step(0, 1'b1, 8'h00, 13'h1FFF);
        step(0, 1'b1, 8'h00, 13'h0000);
        // R3: bp=10 with arm set (R7 check follows)
        step(1, 1'b1, 8'h00, '0);
        step(4, 1'b1, 8'h88, '0);
        idle(WC);
        step(0, 1'b1, 8'h00, 13'h0FFF);
        step(0, 1'b1, 8'h00, 13'h1000);
        // R7: armed pin low blocks status write in both variants
        step(1, 1'b0, 8'h00, '0);
        step(4, 1'b0, 8'h0C, '0);
        step(4, 1'b1, 8'h0C, 13'h0001);
        idle(WC);
        step(0, 1'b1, 8'h00, 13'h0001);

        for (int i = 0; i < 1500; i++) begin
            int r;
            int op;
            r = $urandom_range(0, 9);
            op = (r < 3) ? 1 : (r < 4) ? 2 : (r < 6) ? 3 : (r < 8) ? 4 : 0;
            step(op, 1'(($urandom_range(0, 3)) != 0), 8'($urandom), AW'($urandom));
        end
        idle(2);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule